// File: doc/BRIEF.md
# Framebuffer pixel format unpacker

This block turns one word fetched from a framebuffer into a 24-bit pixel, 8 bits each of red, green and blue, for the panel side of a display controller. The pixel layout is picked by a 4-bit format code. The direct formats are 16-bit 5-6-5, 16-bit 1-5-5-5, 24-bit packed, 32-bit unpacked and 32-bit with an alpha byte. The indexed format takes an 8-bit index and looks it up in a 256-entry palette of 24-bit colours. Narrow channels are widened to 8 bits by copying their top bits into the vacated low bits, so a field that is all ones becomes 0xFF.

The palette is loaded in two steps. Software first places a colour in a staging register. It then issues a command word that carries a fixed commit key and the target index. Channel order comes from the low bit of the format code combined with a panel-side swap flag.

Pixels enter and leave on valid/ready streams. The output register holds a pixel until the sink takes it. A new input word is accepted only when the output register is empty or is being drained in that same cycle. A stalled sink therefore stops the source after at most one word in flight. The format code, the swap flag and the palette enable are captured only when the unpacker is idle. A change made mid-stream takes effect after the stream pauses.

Top module: `pixfmt_unpack`

## Requirements
- R1: Format codes 0 and 1 are 16-bit 5-6-5: the high field is bits 15:11, green is bits 10:5 and the low field is bits 4:0. A 5-bit field v widens to {v, v[4:2]} and a 6-bit field v widens to {v, v[5:4]}.
- R2: Format codes 2 and 3 are 16-bit 1-5-5-5: the high field is bits 14:10, green is bits 9:5 and the low field is bits 4:0, all widened as 5-bit fields. Bit 15 is ignored.
- R3: Codes 4/5 (24-bit packed), 6/7 (32-bit unpacked) and 8/9 (32-bit with alpha) take the high field from bits 23:16, green from bits 15:8 and the low field from bits 7:0. Bits 31:24 are ignored.
- R4: For direct formats, the effective swap is code bit 0 XOR `panel_swap`. When it is 0, red is the high field and blue the low field. When it is 1, the two are exchanged.
- R5: Codes 10 and 11 are indexed. With `pal_lookup_en` set, the output is the palette entry addressed by word bits 7:0, with red in entry bits 23:16, green in 15:8 and blue in 7:0. Neither the swap flag nor code bit 0 has any effect on this output.
- R6: A write with `pal_wdata_we` loads the staging register. A write with `pal_cmd_we` commits the staging value to entry `pal_cmd[7:0]` only when `pal_cmd[15:8]` equals 0x83. Any other key leaves the palette unchanged.
- R7: In indexed mode with `pal_lookup_en` clear, red, green and blue all equal the index byte.
- R8: `in_ready` equals `!out_valid || out_ready`. A word accepted at a clock edge appears on the output, with `out_valid` high, right after that same edge's successor... that is, one clock after acceptance, for every format.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the output channels do not change.
- R10: The format code, `panel_swap` and `pal_lookup_en` are sampled only at a clock edge where both `in_valid` and `out_valid` are low. A change made while a word is held or arriving does not affect that word or the next one accepted back-to-back.
- R11: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_code | input | 4 | Pixel format code (see R1 to R5) |
| panel_swap | input | 1 | Panel-side red/blue exchange flag |
| pal_lookup_en | input | 1 | Enables palette lookup in indexed mode |
| pal_wdata | input | 24 | Colour for the palette staging register |
| pal_wdata_we | input | 1 | Loads `pal_wdata` into the staging register |
| pal_cmd | input | 16 | Commit key in bits 15:8, entry index in bits 7:0 |
| pal_cmd_we | input | 1 | Issues the palette commit command |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Unpacker can take a word |
| in_word | input | 32 | Framebuffer word |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink takes the pixel |
| out_r | output | 8 | Red channel |
| out_g | output | 8 | Green channel |
| out_b | output | 8 | Blue channel |

## Verification
A wrong captured configuration shows up on the very next output pixel as exchanged or misplaced channels. Because of that, every direct format is swept under all four combinations of code bit 0 and the panel flag. The 5-6-5 sweep covers every 16-bit value. A corrupted palette entry or a commit that ignores the key only shows up when that index is read. For this reason all 256 entries are written and then read back after a commit with a bad key. A fault in the hold or ready logic appears within one cycle of a stall, as a changed output or a second accepted word.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;

  localparam int CH_W  = 8;
  localparam int RGB_W = 3 * CH_W;

  typedef enum logic [2:0] {
    GRP_565    = 3'd0,
    GRP_1555   = 3'd1,
    GRP_PACK24 = 3'd2,
    GRP_UNPK32 = 3'd3,
    GRP_ALPHA  = 3'd4,
    GRP_INDEX  = 3'd5
  } fmt_grp_e;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  // Upper three code bits pick the layout; codes 12..15 fall back to unpacked 32-bit
  function automatic fmt_grp_e code_to_grp(input logic [3:0] code);
    case (code[3:1])
      3'd0:    return GRP_565;
      3'd1:    return GRP_1555;
      3'd2:    return GRP_PACK24;
      3'd3:    return GRP_UNPK32;
      3'd4:    return GRP_ALPHA;
      3'd5:    return GRP_INDEX;
      default: return GRP_UNPK32;
    endcase
  endfunction

  function automatic logic [CH_W-1:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [CH_W-1:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

endpackage

// File: rtl/pixfmt_decode.sv
module pixfmt_decode
  import pixfmt_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  fmt_grp_e          grp,
  input  logic              swap,
  output rgb_t              rgb
);

  logic [CH_W-1:0] hi_ch, mid_ch, lo_ch;

  always_comb begin
    case (grp)
      GRP_565: begin
        hi_ch  = widen5(word[15:11]);
        mid_ch = widen6(word[10:5]);
        lo_ch  = widen5(word[4:0]);
      end
      GRP_1555: begin
        hi_ch  = widen5(word[14:10]);
        mid_ch = widen5(word[9:5]);
        lo_ch  = widen5(word[4:0]);
      end
      GRP_INDEX: begin
        hi_ch  = word[7:0];
        mid_ch = word[7:0];
        lo_ch  = word[7:0];
      end
      default: begin
        hi_ch  = word[23:16];
        mid_ch = word[15:8];
        lo_ch  = word[7:0];
      end
    endcase
    rgb.g = mid_ch;
    if (swap && grp != GRP_INDEX) begin
      rgb.r = lo_ch;
      rgb.b = hi_ch;
    end else begin
      rgb.r = hi_ch;
      rgb.b = lo_ch;
    end
  end

  // R1: full-scale 5-bit red field in red-first 565 must widen to all ones
  always_comb begin
    if (grp == GRP_565 && !swap && word[15:11] == 5'h1F)
      a_fullscale_r1: assert (rgb.r == 8'hFF);
  end

endmodule

// File: rtl/pixfmt_palette.sv
module pixfmt_palette
  import pixfmt_pkg::*;
#(
  parameter int          IDX_W  = 8,
  parameter int          CMD_W  = 16,
  parameter logic [7:0]  CMD_KEY = 8'h83
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RGB_W-1:0] wdata,
  input  logic             wdata_we,
  input  logic [CMD_W-1:0] cmd,
  input  logic             cmd_we,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [RGB_W-1:0] rd_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [RGB_W-1:0] stage_q;
  logic [RGB_W-1:0] mem [DEPTH];
  logic             commit;

  assign commit = cmd_we && (cmd[CMD_W-1:CMD_W-8] == CMD_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (wdata_we) stage_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (commit) mem[cmd[IDX_W-1:0]] <= stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_idx];
  end

  // R6: the read port only moves when a lookup is requested
  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/pixfmt_unpack.sv
module pixfmt_unpack
  import pixfmt_pkg::*;
#(
  parameter int         WORD_W  = 32,
  parameter int         IDX_W   = 8,
  parameter int         CMD_W   = 16,
  parameter logic [7:0] CMD_KEY = 8'h83
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        fmt_code,
  input  logic              panel_swap,
  input  logic              pal_lookup_en,
  input  logic [RGB_W-1:0]  pal_wdata,
  input  logic              pal_wdata_we,
  input  logic [CMD_W-1:0]  pal_cmd,
  input  logic              pal_cmd_we,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_r,
  output logic [CH_W-1:0]   out_g,
  output logic [CH_W-1:0]   out_b
);

  fmt_grp_e         grp_q;
  logic             swap_q, lut_q;
  logic             idle, accept, pal_rd;
  logic             use_pal_q;
  rgb_t             dir_rgb, dir_q, out_rgb;
  logic [RGB_W-1:0] pal_data;

  assign idle     = !in_valid && !out_valid;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign pal_rd   = accept && grp_q == GRP_INDEX && lut_q;

  // Configuration is captured only between streams
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= GRP_565;
      swap_q <= 1'b0;
      lut_q  <= 1'b0;
    end else if (idle) begin
      grp_q  <= code_to_grp(fmt_code);
      swap_q <= fmt_code[0] ^ panel_swap;
      lut_q  <= pal_lookup_en;
    end
  end

  pixfmt_decode #(.WORD_W(WORD_W)) u_decode (
    .word (in_word),
    .grp  (grp_q),
    .swap (swap_q),
    .rgb  (dir_rgb)
  );

  pixfmt_palette #(.IDX_W(IDX_W), .CMD_W(CMD_W), .CMD_KEY(CMD_KEY)) u_palette (
    .clk      (clk),
    .rst_n    (rst_n),
    .wdata    (pal_wdata),
    .wdata_we (pal_wdata_we),
    .cmd      (pal_cmd),
    .cmd_we   (pal_cmd_we),
    .rd_en    (pal_rd),
    .rd_idx   (in_word[IDX_W-1:0]),
    .rd_data  (pal_data)
  );

  // Single output stage, matched to the palette read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dir_q     <= '0;
      use_pal_q <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        dir_q     <= dir_rgb;
        use_pal_q <= pal_rd;
      end
    end
  end

  assign out_rgb = use_pal_q ? rgb_t'(pal_data) : dir_q;
  assign out_r   = out_rgb.r;
  assign out_g   = out_rgb.g;
  assign out_b   = out_rgb.b;

  // R8: an accepted word is presented on the next cycle
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8: a held, unconsumed pixel blocks the input
  p_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: stalled output keeps its pixel
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));

  // R10: configuration frozen while traffic is present
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid || out_valid) |=> ($stable(grp_q) && $stable(swap_q) && $stable(lut_q)));

endmodule

// File: tb/pixfmt_unpack_bench.sv
module pixfmt_unpack_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  fmt_code = '0;
  logic        panel_swap = 1'b0;
  logic        pal_lookup_en = 1'b0;
  logic [23:0] pal_wdata = '0;
  logic        pal_wdata_we = 1'b0;
  logic [15:0] pal_cmd = '0;
  logic        pal_cmd_we = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_r, out_g, out_b;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixfmt_unpack u_pixfmt_unpack (
    .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code), .panel_swap(panel_swap),
    .pal_lookup_en(pal_lookup_en), .pal_wdata(pal_wdata), .pal_wdata_we(pal_wdata_we),
    .pal_cmd(pal_cmd), .pal_cmd_we(pal_cmd_we), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  function automatic int w5(int v); return ((v << 3) | (v >> 2)) & 255; endfunction
  function automatic int w6(int v); return ((v << 2) | (v >> 4)) & 255; endfunction
  function automatic logic [23:0] pal_val(int i);
    return {i[7:0], ~i[7:0], i[7:0] ^ 8'h5A};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected pixel for a direct format, from the requirement text
  function automatic logic [23:0] exp_direct(int code, bit pswap, logic [31:0] w);
    int hi, mid, lo;
    bit sw;
    sw = code[0] ^ pswap;
    if (code < 2) begin
      hi = w5(int'(w[15:11])); mid = w6(int'(w[10:5])); lo = w5(int'(w[4:0]));
    end else if (code < 4) begin
      hi = w5(int'(w[14:10])); mid = w5(int'(w[9:5])); lo = w5(int'(w[4:0]));
    end else begin
      hi = int'(w[23:16]); mid = int'(w[15:8]); lo = int'(w[7:0]);
    end
    if (sw) return {lo[7:0], mid[7:0], hi[7:0]};
    return {hi[7:0], mid[7:0], lo[7:0]};
  endfunction

  // Called at a negedge with the stream idle-able; leaves at a negedge
  task automatic set_cfg(input int code, input bit pswap, input bit lut);
    in_valid      = 1'b0;
    fmt_code      = code[3:0];
    panel_swap    = pswap;
    pal_lookup_en = lut;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  // Back-to-back push: drive at a negedge, check at the next negedge
  task automatic push(input string tag, input logic [31:0] w, input logic [23:0] exp);
    in_valid = 1'b1;
    in_word  = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (!out_valid || {out_r, out_g, out_b} !== exp) begin
      total++; bad++;
      $display("FAIL %s word=%h actual=%b/%h expected=1/%h", tag, w, out_valid,
               {out_r, out_g, out_b}, exp);
    end else total++;
  endtask

  task automatic pal_write(input int idx, input logic [23:0] val, input logic [7:0] key);
    pal_wdata = val; pal_wdata_we = 1'b1;
    @(negedge clk);
    pal_wdata_we = 1'b0;
    pal_cmd = {key, idx[7:0]}; pal_cmd_we = 1'b1;
    @(negedge clk);
    pal_cmd_we = 1'b0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [23:0] held;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R11 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R11 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // R1: every 16-bit word in red-first 5-6-5
    set_cfg(0, 1'b0, 1'b0);
    for (int i = 0; i < 65536; i++) push("R1 565", 32'(i), exp_direct(0, 1'b0, 32'(i)));

    // R1 with R4: the other three swap combinations
    for (int c = 0; c < 4; c++) begin
      if (c == 0) continue;
      set_cfg(c[0], c[1], 1'b0);
      for (int i = 0; i < 2048; i++) begin
        w = 32'(i * 40503) & 32'hFFFF;
        push("R4 565 swap", w, exp_direct(c[0], c[1], w));
      end
    end

    // R2: 1-5-5-5 with bit 15 varied, all swap combinations
    for (int c = 0; c < 4; c++) begin
      set_cfg(2 + c[0], c[1], 1'b0);
      for (int i = 0; i < 4096; i++) begin
        w = 32'(i * 7919) & 32'hFFFF;
        push("R2 1555", w, exp_direct(2 + c[0], c[1], w));
      end
    end

    // R3 with R4: 24/32-bit formats, top byte noise ignored
    for (int code = 4; code < 10; code++) begin
      for (int p = 0; p < 2; p++) begin
        set_cfg(code, p[0], 1'b0);
        for (int i = 0; i < 512; i++) begin
          w = 32'(i) * 32'h9E3779B1;
          push("R3 888", w, exp_direct(code, p[0], w));
        end
      end
    end

    // R6: load the palette, then a commit with a wrong key must not land
    for (int i = 0; i < 256; i++) pal_write(i, pal_val(i), 8'h83);
    pal_write(5, 24'h123456, 8'h82);
    pal_write(77, 24'hABCDEF, 8'h03);

    // R5 and R6: read every entry, panel swap set and code bit 0 set (no effect)
    set_cfg(11, 1'b1, 1'b1);
    for (int i = 0; i < 256; i++)
      push("R5 R6 palette", 32'hFFFF_FF00 | 32'(i), pal_val(i));
    set_cfg(10, 1'b0, 1'b1);
    push("R6 bad key entry 5", 32'd5, pal_val(5));
    push("R6 bad key entry 77", 32'd77, pal_val(77));

    // R7: lookup disabled gives a grey level equal to the index
    set_cfg(10, 1'b1, 1'b0);
    for (int i = 0; i < 256; i++)
      push("R7 grey", 32'h0000_AB00 | 32'(i), {i[7:0], i[7:0], i[7:0]});

    // R9, R8, R10: stall with a format change pending
    set_cfg(0, 1'b0, 1'b0);
    out_ready = 1'b0;
    in_valid = 1'b1; in_word = 32'h0000_F81F;
    @(posedge clk);
    @(negedge clk);
    fmt_code = 4'd4;  // arrives while a pixel is held
    held = exp_direct(0, 1'b0, 32'h0000_F81F);
    in_word = 32'h0000_07E0;
    check("R8 in_ready low while held", {31'd0, in_ready}, 32'd0);
    repeat (3) @(negedge clk);
    check("R9 held valid", {31'd0, out_valid}, 32'd1);
    check("R9 held pixel", {8'd0, out_r, out_g, out_b}, {8'd0, held});
    check("R8 in_ready still low", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next word keeps old format", {8'd0, out_r, out_g, out_b},
          {8'd0, exp_direct(0, 1'b0, 32'h0000_07E0)});
    check("R8 one-cycle latency", {31'd0, out_valid}, 32'd1);
    set_cfg(4, 1'b0, 1'b0);
    push("R10 new format after idle", 32'h0000_07E0, exp_direct(4, 1'b0, 32'h0000_07E0));
    @(negedge clk);
    check("R8 drained", {31'd0, out_valid}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule